// File: doc/BRIEF.md
# Shared Pin Function Configuration Controller

This block lets three package pins each carry one of several functions. A configuration code, written by software elsewhere, picks one of eight legal pin-function combinations. A spread-select field can then turn one frequency-select pin into a spread-enable control. From the selected combination the block builds a set of role strobes. It uses them to route the synchronized levels on the input pins to internal controls: a global output enable, a power-down request, three frequency-select bits, a spread enable, and the serial clock and data lines. For pins that carry a clock, the block passes the internal clock through and drives the pin's output enable.

Codes outside the legal set are rejected. A spread-enable assignment on a pin that is not a frequency-select pin in the chosen combination is also rejected. This covers the combinations that use the analog tuning input or the serial interface. In both cases the block falls back to the first combination with no spread, and it raises an error flag. The serial protocol engine and the analog tuning path live outside this block. The block only selects the pins for them and passes the levels along.

Top module: `pinmux_cfg_ctrl`

## Requirements
- R1: Pin indices are 0, 1 and 2. The combination codes map as follows, with the roles listed for pins 0/1/2: 0 = FS/CLK/CLK, 1 = FS/CLK/FS, 2 = FS/FS/FS, 3 = ENPD/CLK/CLK, 4 = ENPD/FS/CLK, 5 = ENPD/FS/FS, 6 = SDATA/SCLK/CLK, 7 = TUNE/CLK/CLK. A new code takes effect one rising edge after it is applied.
- R2: A code of 8 or more applies the roles of code 0 with no spread pin and sets `cfgErr` to 1. A legal code with a legal spread selection gives `cfgErr` = 0.
- R3: `spreadSel` 0 means no spread pin; values 1, 2 and 3 select pin 0, 1 and 2. If the selected pin is FS in the chosen combination, `spreadEn` follows that pin and its `freqSel` bit reads 0. Otherwise the roles of code 0 apply with no spread pin, and `cfgErr` = 1.
- R4: `freqSel[i]` equals the synchronized level of pin i when pin i has the FS role, and 0 otherwise.
- R5: With the ENPD role and `pdMode` = 0, `globalOe` follows pin 0. With no ENPD role, `globalOe` is 1. Clock pins are enabled only while `globalOe` is 1.
- R6: With the ENPD role and `pdMode` = 1, a low pin 0 sets `pwrDownReq` and clears every bit of `padOe`. In this mode `globalOe` is 1.
- R7: `padOut[1]` = `clkBIn` and `padOut[2]` = `clkCIn` at all times. `padOe[i]` for i = 1 or 2 is 1 only for a CLK-role pin while outputs are enabled and no power-down is requested.
- R8: In combination 6, `sclkOut` follows pin 1, `sdatOut` follows pin 0, `padOut[0]` = 0 and `padOe[0]` = `sdatLowReq`. In every other combination, `sclkOut` = `sdatOut` = 1 and `padOe[0]` = 0, whatever `sdatLowReq` is.
- R9: `tuneSel` is 1 only in combination 7. In that combination the level on pin 0 has no effect on any output.
- R10: A pin level change reaches the outputs after exactly two rising edges. Asynchronous reset presets the synchronizer to all ones and the roles to those of code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCode | input | 4 | Combination code |
| spreadSel | input | 2 | Spread pin select (0 none, 1..3 pin 0..2) |
| pdMode | input | 1 | ENPD pin acts as power-down (1) or output enable (0) |
| padIn | input | 3 | Levels seen on the three pins |
| clkBIn | input | 1 | Internal clock for pin 1 |
| clkCIn | input | 1 | Internal clock for pin 2 |
| sdatLowReq | input | 1 | Serial engine pulls data low |
| globalOe | output | 1 | Global output enable |
| pwrDownReq | output | 1 | Low-power request |
| freqSel | output | 3 | Frequency-select bits |
| spreadEn | output | 1 | Spread enable |
| sclkOut | output | 1 | Serial clock to engine |
| sdatOut | output | 1 | Serial data to engine |
| tuneSel | output | 1 | Analog tuning input selected |
| cfgErr | output | 1 | Illegal configuration seen |
| padOut | output | 3 | Pin output values |
| padOe | output | 3 | Pin output enables |

## Verification
The bench builds the block with its default parameters: a 4-bit code and a two-stage synchronizer. The 4-bit code leaves codes 8 to 15 illegal, so the fallback path can be driven directly. The two-stage depth lets the bench count the exact edge on which a pin level appears. Every legal combination is driven with two different pin patterns. Each rejected spread pairing is driven as well, including the ones with the tuning input and the serial interface.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_PINS   = 3;
  localparam int NUM_COMBOS = 8;

  typedef enum logic [2:0] {
    COMBO_FS_CC  = 3'd0,
    COMBO_FS_CF  = 3'd1,
    COMBO_FS_FF  = 3'd2,
    COMBO_EN_CC  = 3'd3,
    COMBO_EN_FC  = 3'd4,
    COMBO_EN_FF  = 3'd5,
    COMBO_SER_C  = 3'd6,
    COMBO_TUNE_C = 3'd7
  } comboT;

  // role strobes from control to datapath
  typedef struct packed {
    logic [NUM_PINS-1:0] fsEn;
    logic [NUM_PINS-1:0] spreadPin;
    logic [NUM_PINS-1:0] clkEn;
    logic                oeEn;
    logic                pdEn;
    logic                serialEn;
    logic                tuneEn;
    logic                err;
  } roleT;

  function automatic roleT rolesFor(comboT combo, logic pdMode);
    roleT r;
    logic enpd;
    r    = '0;
    enpd = 1'b0;
    unique case (combo)
      COMBO_FS_CC:  begin r.fsEn = 3'b001; r.clkEn = 3'b110; end
      COMBO_FS_CF:  begin r.fsEn = 3'b101; r.clkEn = 3'b010; end
      COMBO_FS_FF:  begin r.fsEn = 3'b111; r.clkEn = 3'b000; end
      COMBO_EN_CC:  begin enpd = 1'b1; r.fsEn = 3'b000; r.clkEn = 3'b110; end
      COMBO_EN_FC:  begin enpd = 1'b1; r.fsEn = 3'b010; r.clkEn = 3'b100; end
      COMBO_EN_FF:  begin enpd = 1'b1; r.fsEn = 3'b110; r.clkEn = 3'b000; end
      COMBO_SER_C:  begin r.serialEn = 1'b1; r.clkEn = 3'b100; end
      COMBO_TUNE_C: begin r.tuneEn = 1'b1; r.clkEn = 3'b110; end
      default:      begin r.fsEn = 3'b001; r.clkEn = 3'b110; end
    endcase
    r.oeEn = enpd & ~pdMode;
    r.pdEn = enpd & pdMode;
    return r;
  endfunction
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    logic [WIDTH-1:0] stageD;
    if (g == 0) begin : gFirst
      assign stageD = din;
    end else begin : gNext
      assign stageD = stageQ[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[g] <= RESET_VAL;
      else       stageQ[g] <= stageD;
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [1:0]        spreadSel,
  input  logic              pdMode,
  output roleT              roles
);
  localparam logic [CODE_W-1:0] LEGAL_LIMIT = CODE_W'(NUM_COMBOS);

  roleT baseRoles;
  roleT safeRoles;
  roleT nextRoles;
  logic codeLegal;
  logic [NUM_PINS-1:0] spreadMask;

  assign codeLegal = cfgCode < LEGAL_LIMIT;
  assign baseRoles = rolesFor(comboT'(cfgCode[2:0]), pdMode);
  assign safeRoles = rolesFor(COMBO_FS_CC, pdMode);

  always_comb begin
    unique case (spreadSel)
      2'd1:    spreadMask = 3'b001;
      2'd2:    spreadMask = 3'b010;
      2'd3:    spreadMask = 3'b100;
      default: spreadMask = 3'b000;
    endcase
  end

  always_comb begin
    nextRoles = baseRoles;
    if (!codeLegal) begin
      nextRoles     = safeRoles;
      nextRoles.err = 1'b1;
    end else if ((spreadMask & ~baseRoles.fsEn) != '0) begin
      // spread requested on a pin that is not a frequency-select pin
      nextRoles     = safeRoles;
      nextRoles.err = 1'b1;
    end else begin
      nextRoles.spreadPin = spreadMask;
      nextRoles.fsEn      = baseRoles.fsEn & ~spreadMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) roles <= rolesFor(COMBO_FS_CC, 1'b0);
    else       roles <= nextRoles;
  end
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
(
  input  roleT                roles,
  input  logic [NUM_PINS-1:0] pinLvl,
  input  logic                clkBIn,
  input  logic                clkCIn,
  input  logic                sdatLowReq,
  output logic                globalOe,
  output logic                pwrDownReq,
  output logic [NUM_PINS-1:0] freqSel,
  output logic                spreadEn,
  output logic                sclkOut,
  output logic                sdatOut,
  output logic                tuneSel,
  output logic                cfgErr,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  logic driveOk;

  assign globalOe   = roles.oeEn ? pinLvl[0] : 1'b1;
  assign pwrDownReq = roles.pdEn & ~pinLvl[0];
  assign freqSel    = roles.fsEn & pinLvl;
  assign spreadEn   = |(roles.spreadPin & pinLvl);
  assign sclkOut    = roles.serialEn ? pinLvl[1] : 1'b1;
  assign sdatOut    = roles.serialEn ? pinLvl[0] : 1'b1;
  assign tuneSel    = roles.tuneEn;
  assign cfgErr     = roles.err;
  assign driveOk    = globalOe & ~pwrDownReq;

  // pin 0 only ever drives low for the serial data line
  assign padOut = {clkCIn, clkBIn, 1'b0};
  assign padOe  = {roles.clkEn[2] & driveOk,
                   roles.clkEn[1] & driveOk,
                   roles.serialEn & sdatLowReq};
endmodule

// File: rtl/pinmux_cfg_ctrl.sv
module pinmux_cfg_ctrl
  import pinmux_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [1:0]        spreadSel,
  input  logic              pdMode,
  input  logic [2:0]        padIn,
  input  logic              clkBIn,
  input  logic              clkCIn,
  input  logic              sdatLowReq,
  output logic              globalOe,
  output logic              pwrDownReq,
  output logic [2:0]        freqSel,
  output logic              spreadEn,
  output logic              sclkOut,
  output logic              sdatOut,
  output logic              tuneSel,
  output logic              cfgErr,
  output logic [2:0]        padOut,
  output logic [2:0]        padOe
);
  roleT roles;
  logic [NUM_PINS-1:0] pinLvl;

  pinmux_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RESET_VAL('1)) uSync (
    .clk(clk), .rstN(rstN), .din(padIn), .dout(pinLvl)
  );

  pinmux_ctrl #(.CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgCode(cfgCode), .spreadSel(spreadSel),
    .pdMode(pdMode), .roles(roles)
  );

  pinmux_route uRoute (
    .roles(roles), .pinLvl(pinLvl), .clkBIn(clkBIn), .clkCIn(clkCIn),
    .sdatLowReq(sdatLowReq), .globalOe(globalOe), .pwrDownReq(pwrDownReq),
    .freqSel(freqSel), .spreadEn(spreadEn), .sclkOut(sclkOut),
    .sdatOut(sdatOut), .tuneSel(tuneSel), .cfgErr(cfgErr),
    .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/pinmux_cfg_ctrl_chk.sv
module pinmux_cfg_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       globalOe,
  input logic       pwrDownReq,
  input logic [2:0] freqSel,
  input logic       spreadEn,
  input logic       sclkOut,
  input logic       sdatOut,
  input logic       tuneSel,
  input logic       cfgErr,
  input logic [2:0] padOe
);
  // R6
  pd_tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownReq |-> padOe == 3'b000);

  // R2
  err_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!tuneSel && !spreadEn && freqSel[2:1] == 2'b00 && sclkOut && sdatOut));

  // R9
  tune_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    tuneSel |-> (!spreadEn && sclkOut && sdatOut && freqSel == 3'b000 && !cfgErr));

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalOe |-> padOe[2:1] == 2'b00);

  // R3
  spread_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    spreadEn |-> !cfgErr);
endmodule

bind pinmux_cfg_ctrl pinmux_cfg_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .globalOe(globalOe), .pwrDownReq(pwrDownReq),
  .freqSel(freqSel), .spreadEn(spreadEn), .sclkOut(sclkOut), .sdatOut(sdatOut),
  .tuneSel(tuneSel), .cfgErr(cfgErr), .padOe(padOe)
);

// File: tb/tb_pinmux_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_pinmux_cfg_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cfgCode = 4'd0;
  logic [1:0] spreadSel = 2'd0;
  logic pdMode = 1'b0;
  logic [2:0] padIn = 3'b000;
  logic clkBIn = 1'b0, clkCIn = 1'b0, sdatLowReq = 1'b0;
  logic globalOe, pwrDownReq, spreadEn, sclkOut, sdatOut, tuneSel, cfgErr;
  logic [2:0] freqSel, padOut, padOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } itemT;
  itemT sbq[$];

  always #2.5 clk = ~clk;

  pinmux_cfg_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgCode(cfgCode), .spreadSel(spreadSel),
    .pdMode(pdMode), .padIn(padIn), .clkBIn(clkBIn), .clkCIn(clkCIn),
    .sdatLowReq(sdatLowReq), .globalOe(globalOe), .pwrDownReq(pwrDownReq),
    .freqSel(freqSel), .spreadEn(spreadEn), .sclkOut(sclkOut),
    .sdatOut(sdatOut), .tuneSel(tuneSel), .cfgErr(cfgErr),
    .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [15:0] actual();
    return {globalOe, pwrDownReq, freqSel, spreadEn, sclkOut, sdatOut,
            tuneSel, cfgErr, padOut, padOe};
  endfunction

  // expected outputs, worked out from the requirement text
  function automatic logic [15:0] model(input logic [3:0] code, input logic [1:0] ss,
      input logic pdm, input logic [2:0] lvl, input logic sdl, input logic cb, input logic cc);
    logic [2:0] fs, ck, sp, mask, fsq, oe;
    logic enpd, ser, tune, err, gOe, pd, drv;
    fs = 3'b001; ck = 3'b110; enpd = 0; ser = 0; tune = 0; err = 0; sp = 3'b000;
    if (code > 4'd7) err = 1;
    else begin
      case (code[2:0])
        3'd1: begin fs = 3'b101; ck = 3'b010; end
        3'd2: begin fs = 3'b111; ck = 3'b000; end
        3'd3: begin fs = 3'b000; ck = 3'b110; enpd = 1; end
        3'd4: begin fs = 3'b010; ck = 3'b100; enpd = 1; end
        3'd5: begin fs = 3'b110; ck = 3'b000; enpd = 1; end
        3'd6: begin fs = 3'b000; ck = 3'b100; ser = 1; end
        3'd7: begin fs = 3'b000; ck = 3'b110; tune = 1; end
        default: ;
      endcase
      mask = (ss == 2'd0) ? 3'b000 : (3'b001 << (ss - 2'd1));
      if ((mask & ~fs) != 3'b000) begin
        err = 1; fs = 3'b001; ck = 3'b110; enpd = 0; ser = 0; tune = 0;
      end else begin
        sp = mask; fs = fs & ~mask;
      end
    end
    gOe = (enpd && !pdm) ? lvl[0] : 1'b1;
    pd  = enpd && pdm && !lvl[0];
    drv = gOe && !pd;
    fsq = fs & lvl;
    oe  = {ck[2] & drv, ck[1] & drv, ser & sdl};
    return {gOe, pd, fsq, |(sp & lvl), ser ? lvl[1] : 1'b1, ser ? lvl[0] : 1'b1,
            tune, err, {cc, cb, 1'b0}, oe};
  endfunction

  task automatic compare(input logic [15:0] exp, input string tag);
    logic [15:0] act;
    act = actual();
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design presents its results
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      itemT it;
      it = sbq.pop_front();
      compare(it.exp, it.tag);
    end
  end

  task automatic apply(input logic [3:0] code, input logic [1:0] ss, input logic pdm,
      input logic [2:0] lvl, input logic sdl, input string tag);
    itemT it;
    @(negedge clk); #1;
    cfgCode = code; spreadSel = ss; pdMode = pdm; padIn = lvl; sdatLowReq = sdl;
    repeat (3) @(posedge clk);
    #1;
    it.exp = model(code, ss, pdm, lvl, sdl, clkBIn, clkCIn);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    #200000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R10: reset state, synchronizer preset high and roles of code 0
    #7;
    compare(model(4'd0, 2'd0, 1'b0, 3'b111, 1'b0, 1'b0, 1'b0), "R10 reset");
    @(negedge clk); #1 rstN = 1'b1;

    // R1 R4: every legal combination under two pin patterns
    for (int c = 0; c < 8; c++) begin
      apply(4'(c), 2'd0, 1'b0, 3'b101, 1'b0, "R1 pattern 101");
      apply(4'(c), 2'd0, 1'b0, 3'b010, 1'b0, "R4 pattern 010");
    end
    apply(4'd2, 2'd0, 1'b0, 3'b110, 1'b0, "R4 all-FS 110");

    // R2: illegal codes
    apply(4'd8, 2'd0, 1'b0, 3'b111, 1'b0, "R2 code 8");
    apply(4'd15, 2'd3, 1'b0, 3'b111, 1'b0, "R2 code 15");

    // R3: spread pin selection, legal and rejected
    apply(4'd2, 2'd2, 1'b0, 3'b010, 1'b0, "R3 spread pin1 high");
    apply(4'd2, 2'd2, 1'b0, 3'b101, 1'b0, "R3 spread pin1 low");
    apply(4'd1, 2'd3, 1'b0, 3'b100, 1'b0, "R3 spread pin2");
    apply(4'd0, 2'd2, 1'b0, 3'b111, 1'b0, "R3 spread on clock pin");
    apply(4'd7, 2'd1, 1'b0, 3'b111, 1'b0, "R3 spread with tune");
    apply(4'd6, 2'd2, 1'b0, 3'b111, 1'b0, "R3 spread with serial");

    // R5: output enable mode
    apply(4'd3, 2'd0, 1'b0, 3'b000, 1'b0, "R5 enable low");
    apply(4'd3, 2'd0, 1'b0, 3'b001, 1'b0, "R5 enable high");

    // R6: power-down mode
    apply(4'd4, 2'd0, 1'b1, 3'b010, 1'b0, "R6 power-down low");
    apply(4'd4, 2'd0, 1'b1, 3'b011, 1'b0, "R6 power-down high");

    // R7: clock passthrough
    drain();
    clkBIn = 1'b1; clkCIn = 1'b0;
    apply(4'd0, 2'd0, 1'b0, 3'b000, 1'b0, "R7 clocks 10");
    drain();
    clkBIn = 1'b0; clkCIn = 1'b1;
    apply(4'd0, 2'd0, 1'b0, 3'b000, 1'b0, "R7 clocks 01");

    // R8: serial pins
    apply(4'd6, 2'd0, 1'b0, 3'b011, 1'b1, "R8 serial drive low");
    apply(4'd6, 2'd0, 1'b0, 3'b001, 1'b0, "R8 serial released");
    apply(4'd0, 2'd0, 1'b0, 3'b011, 1'b1, "R8 drive ignored");

    // R9: tuning pin level has no effect
    apply(4'd7, 2'd0, 1'b0, 3'b000, 1'b0, "R9 tune pin low");
    apply(4'd7, 2'd0, 1'b0, 3'b001, 1'b0, "R9 tune pin high");

    // R10: pin level latency of two edges
    apply(4'd2, 2'd0, 1'b0, 3'b000, 1'b0, "R10 settle");
    drain();
    padIn = 3'b111;
    @(posedge clk); #1;
    compare(model(4'd2, 2'd0, 1'b0, 3'b000, 1'b0, clkBIn, clkCIn), "R10 one edge");
    @(posedge clk); #1;
    compare(model(4'd2, 2'd0, 1'b0, 3'b111, 1'b0, clkBIn, clkCIn), "R10 two edges");

    // R1: configuration latency of one edge
    cfgCode = 4'd0;
    padIn = 3'b110;
    repeat (3) @(posedge clk);
    #1;
    cfgCode = 4'd2;
    compare(model(4'd0, 2'd0, 1'b0, 3'b110, 1'b0, clkBIn, clkCIn), "R1 before edge");
    @(posedge clk); #1;
    compare(model(4'd2, 2'd0, 1'b0, 3'b110, 1'b0, clkBIn, clkCIn), "R1 after edge");

    drain();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule